// File: doc/BRIEF.md
# CAN Controller Low-Power Sequencer

This block decides when a CAN protocol controller may stop its logic and when it may start again. Software asks for one of two static low-power states through a small control register. The first is a sleep state that activity on the receive line can end. The second is a power-down state that only software or a system reset can end. A request never cuts a frame short. It waits until the protocol engine reports no frame in progress and no lost arbitration, unless an error condition forces it through at once.

When the controller leaves either state, it does not resume straight away. It first counts recessive bits, one per bit-time tick, at the bit timing in use before entry. Any dominant bit restarts that count. The same warm-up applies after a system reset. The two request bits read back as 1 only while the low-power state is actually entered. The block also gates the controller's error and status interrupt requests with their local enables and the global CAN interrupt enable.

Register layout (write `wr_data`, read `rd_data`): bit 0 sleep request, bit 1 power-down request, bit 2 controller reset, bit 3 software interrupt, bit 4 status interrupt enable, bit 5 error interrupt enable, bits 7:6 read 0.

Top module: `can_lp_seq`

## Requirements
- R1: After reset `rd_data` is 0x0C (controller reset and software interrupt set, all other bits 0). `wake_flag` is 0, `core_run_en` is 1 and `resume_ready` is 0.
- R2: A sleep or power-down request is held off while `frame_active` or `arb_lost` is high. When both are low, the low-power state is entered at the next clock edge.
- R3: An `err_event` lets a pending request enter the low-power state even while a frame is in progress.
- R4: In sleep with the power-down bit clear, a high-to-low transition on the synchronised `rx_line` clears the sleep bit and leaves the low-power state.
- R5: Sleep also ends when software writes the sleep bit to 0, or writes a 1 to the controller-reset bit or the software-interrupt bit. A write that sets either of those two bits stores the sleep bit as 0.
- R6: While the power-down bit is set, activity on `rx_line` does not leave the low-power state. Clearing the power-down bit does.
- R7: After reset and after every exit, `resume_ready` stays 0 until 11 consecutive `bit_tick` pulses have each seen a recessive (1) line. A tick that sees a dominant line restarts the count.
- R8: A `core_irq` pulse while a sleep request is pending clears the sleep bit, and the sleep request does not enter the low-power state. This holds even in the cycle in which the frame ends.
- R9: Bits 0 and 1 of `rd_data` read 0 while the low-power state is not entered. While it is entered, they return the stored request bits, whichever request caused the entry.
- R10: `wake_flag` is 1 exactly while the low-power state is entered, and `core_run_en` is its inverse.
- R11: `err_irq` equals `global_ie` AND error enable AND (`evt_bus_status` OR `evt_err_ec96`).
- R12: `stat_irq` equals `global_ie` AND status enable AND (`evt_err_code` OR `evt_tx_done` OR `evt_rx_done` OR `wake_flag`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low system reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register readback |
| frame_active | input | 1 | Protocol engine is receiving or sending a frame |
| arb_lost | input | 1 | Arbitration lost this cycle |
| err_event | input | 1 | Error condition ends the current activity |
| core_irq | input | 1 | Engine raised an interrupt from an active transfer |
| rx_line | input | 1 | Asynchronous receive line, 1 = recessive |
| bit_tick | input | 1 | One pulse per nominal bit time |
| global_ie | input | 1 | Global CAN interrupt enable |
| evt_bus_status | input | 1 | Bus status change event |
| evt_err_ec96 | input | 1 | Error count above 96 event |
| evt_err_code | input | 1 | Error code status event |
| evt_tx_done | input | 1 | Transmit status event |
| evt_rx_done | input | 1 | Receive status event |
| core_run_en | output | 1 | Clock-gate / static enable for the controller logic |
| wake_flag | output | 1 | Low-power state entered |
| resume_ready | output | 1 | Warm-up finished, protocol operation may run |
| err_irq | output | 1 | Gated error interrupt request |
| stat_irq | output | 1 | Gated status interrupt request |

## Verification
A sleep request can be entered and aborted in the same cycle. This happens when `frame_active` falls in the same clock as `core_irq` is pulsed. The bench drives both together and then waits several idle cycles. A correct block keeps `wake_flag` at 0 because the abort wins. A second collision pits bus activity against a power-down bit set alongside sleep. The bench raises both requests, drives the line dominant and expects the state to hold until software clears the power-down bit.

// File: rtl/can_lp_pkg.sv
package can_lp_pkg;

  typedef enum logic [1:0] {
    ST_RECOVER = 2'd0,
    ST_RUN     = 2'd1,
    ST_LOWPWR  = 2'd2
  } lp_state_t;

  localparam int unsigned F_SLEEP = 0;
  localparam int unsigned F_PDOWN = 1;
  localparam int unsigned F_CRST  = 2;
  localparam int unsigned F_SWINT = 3;
  localparam int unsigned F_STIE  = 4;
  localparam int unsigned F_ERIE  = 5;

  // Recessive run counter step: saturating count, cleared by a dominant bit.
  function automatic int unsigned next_run(input int unsigned cnt,
                                           input logic recessive,
                                           input int unsigned limit);
    if (!recessive) return 0;
    if (cnt >= limit) return limit;
    return cnt + 1;
  endfunction

  // Readback of a request bit: only visible once the state is entered.
  function automatic logic shown_req(input logic raw, input logic entered);
    return raw & entered;
  endfunction

  // Interrupt gating arithmetic.
  function automatic logic gate_irq(input logic gie, input logic local_en,
                                    input logic any_evt);
    return gie & local_en & any_evt;
  endfunction

endpackage

// File: rtl/can_lp_rxsync.sv
module can_lp_rxsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_async,
  output logic rx_sync,
  output logic rx_fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= rx_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], rx_async};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign rx_sync = chain_q[STAGES-1];
  assign rx_fall = prev_q & ~rx_sync;

  // A falling edge is only reported after the line was seen recessive.
  assert_fall_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fall |-> $past(rx_sync));
endmodule

// File: rtl/can_lp_regs.sv
module can_lp_regs
  import can_lp_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             hw_clr_sleep,
  output logic             sleep_q,
  output logic             pdown_q,
  output logic             crst_q,
  output logic             swint_q,
  output logic             stie_q,
  output logic             erie_q
);
  logic wr_kicks_sleep;
  assign wr_kicks_sleep = wr_data[F_CRST] | wr_data[F_SWINT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      pdown_q <= 1'b0;
      crst_q  <= 1'b1;
      swint_q <= 1'b1;
      stie_q  <= 1'b0;
      erie_q  <= 1'b0;
    end else if (wr_en) begin
      sleep_q <= wr_data[F_SLEEP] & ~wr_kicks_sleep;
      pdown_q <= wr_data[F_PDOWN];
      crst_q  <= wr_data[F_CRST];
      swint_q <= wr_data[F_SWINT];
      stie_q  <= wr_data[F_STIE];
      erie_q  <= wr_data[F_ERIE];
    end else if (hw_clr_sleep) begin
      sleep_q <= 1'b0;
    end
  end

  assert_kick_clears_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kicks_sleep) |=> !sleep_q);
endmodule

// File: rtl/can_lp_fsm.sv
module can_lp_fsm
  import can_lp_pkg::*;
#(
  parameter int unsigned RUN_BITS = 11
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_q,
  input  logic      pdown_q,
  input  logic      frame_active,
  input  logic      arb_lost,
  input  logic      err_event,
  input  logic      core_irq,
  input  logic      bit_tick,
  input  logic      rx_sync,
  input  logic      rx_fall,
  output lp_state_t state,
  output logic      abort_sleep,
  output logic      bus_wake
);
  localparam int unsigned CW = $clog2(RUN_BITS + 1);

  lp_state_t   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic        busy, want_lp, enter_lp, leave_lp;
  int unsigned run_nxt;

  assign busy        = frame_active | arb_lost;
  assign abort_sleep = (state_q == ST_RUN) & sleep_q & core_irq;
  assign want_lp     = (sleep_q & ~abort_sleep) | pdown_q;
  assign enter_lp    = (state_q == ST_RUN) & want_lp & (~busy | err_event);
  assign bus_wake    = (state_q == ST_LOWPWR) & rx_fall & ~pdown_q;
  assign leave_lp    = (state_q == ST_LOWPWR) & ~sleep_q & ~pdown_q;
  assign run_nxt     = next_run(32'(cnt_q), rx_sync, RUN_BITS);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_RUN: begin
        if (enter_lp) state_d = ST_LOWPWR;
      end
      ST_LOWPWR: begin
        if (leave_lp) begin
          state_d = ST_RECOVER;
          cnt_d   = '0;
        end
      end
      ST_RECOVER: begin
        if (bit_tick) begin
          if (run_nxt >= RUN_BITS) begin
            state_d = ST_RUN;
            cnt_d   = '0;
          end else begin
            cnt_d = CW'(run_nxt);
          end
        end
      end
      default: state_d = ST_RECOVER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RECOVER;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state = state_q;

  assert_defer_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && frame_active && !err_event) |=> state_q != ST_LOWPWR);
  assert_pdown_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOWPWR && pdown_q) |=> state_q == ST_LOWPWR);
  assert_resume_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && $past(state_q) == ST_RECOVER) |-> $past(bit_tick && rx_sync));
  assert_no_skip_recover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOWPWR) |=> state_q != ST_RUN);
endmodule

// File: rtl/can_lp_irq.sv
module can_lp_irq
  import can_lp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic global_ie,
  input  logic erie_q,
  input  logic stie_q,
  input  logic evt_bus_status,
  input  logic evt_err_ec96,
  input  logic evt_err_code,
  input  logic evt_tx_done,
  input  logic evt_rx_done,
  input  logic wake_flag,
  output logic err_irq,
  output logic stat_irq
);
  logic err_any, stat_any;

  assign err_any  = evt_bus_status | evt_err_ec96;
  assign stat_any = evt_err_code | evt_tx_done | evt_rx_done | wake_flag;
  assign err_irq  = gate_irq(global_ie, erie_q, err_any);
  assign stat_irq = gate_irq(global_ie, stie_q, stat_any);

  assert_global_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !global_ie |-> !err_irq);
  assert_global_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !global_ie |-> !stat_irq);
endmodule

// File: rtl/can_lp_seq.sv
module can_lp_seq
  import can_lp_pkg::*;
#(
  parameter int unsigned REG_W       = 8,
  parameter int unsigned RUN_BITS    = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             frame_active,
  input  logic             arb_lost,
  input  logic             err_event,
  input  logic             core_irq,
  input  logic             rx_line,
  input  logic             bit_tick,
  input  logic             global_ie,
  input  logic             evt_bus_status,
  input  logic             evt_err_ec96,
  input  logic             evt_err_code,
  input  logic             evt_tx_done,
  input  logic             evt_rx_done,
  output logic             core_run_en,
  output logic             wake_flag,
  output logic             resume_ready,
  output logic             err_irq,
  output logic             stat_irq
);
  logic      rx_sync, rx_fall;
  logic      sleep_q, pdown_q, crst_q, swint_q, stie_q, erie_q;
  logic      abort_sleep, bus_wake, entered;
  lp_state_t st;

  can_lp_rxsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rx_async(rx_line),
    .rx_sync(rx_sync), .rx_fall(rx_fall)
  );

  can_lp_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hw_clr_sleep(abort_sleep | bus_wake),
    .sleep_q(sleep_q), .pdown_q(pdown_q), .crst_q(crst_q),
    .swint_q(swint_q), .stie_q(stie_q), .erie_q(erie_q)
  );

  can_lp_fsm #(.RUN_BITS(RUN_BITS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_q(sleep_q), .pdown_q(pdown_q),
    .frame_active(frame_active), .arb_lost(arb_lost), .err_event(err_event),
    .core_irq(core_irq), .bit_tick(bit_tick), .rx_sync(rx_sync),
    .rx_fall(rx_fall), .state(st), .abort_sleep(abort_sleep),
    .bus_wake(bus_wake)
  );

  can_lp_irq u_irq (
    .clk(clk), .rst_n(rst_n), .global_ie(global_ie), .erie_q(erie_q),
    .stie_q(stie_q), .evt_bus_status(evt_bus_status),
    .evt_err_ec96(evt_err_ec96), .evt_err_code(evt_err_code),
    .evt_tx_done(evt_tx_done), .evt_rx_done(evt_rx_done),
    .wake_flag(wake_flag), .err_irq(err_irq), .stat_irq(stat_irq)
  );

  assign entered      = (st == ST_LOWPWR);
  assign wake_flag    = entered;
  assign core_run_en  = ~entered;
  assign resume_ready = (st == ST_RUN);

  always_comb begin
    rd_data          = '0;
    rd_data[F_SLEEP] = shown_req(sleep_q, entered);
    rd_data[F_PDOWN] = shown_req(pdown_q, entered);
    rd_data[F_CRST]  = crst_q;
    rd_data[F_SWINT] = swint_q;
    rd_data[F_STIE]  = stie_q;
    rd_data[F_ERIE]  = erie_q;
  end

  assert_read_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_flag |-> (rd_data[F_SLEEP] == 1'b0 && rd_data[F_PDOWN] == 1'b0));
  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_sleep && !wr_en) |=> !sleep_q);
  assert_gate_inverse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_flag != core_run_en);
  assert_bus_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wake && !wr_en) |=> !sleep_q);
endmodule

// File: tb/can_lp_seq_tb.sv
module can_lp_seq_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, wr_en, frame_active, arb_lost, err_event, core_irq;
  logic       rx_line, bit_tick, global_ie;
  logic       evt_bus_status, evt_err_ec96, evt_err_code, evt_tx_done, evt_rx_done;
  logic [7:0] wr_data, rd_data;
  logic       core_run_en, wake_flag, resume_ready, err_irq, stat_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  can_lp_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .frame_active(frame_active), .arb_lost(arb_lost), .err_event(err_event),
    .core_irq(core_irq), .rx_line(rx_line), .bit_tick(bit_tick),
    .global_ie(global_ie), .evt_bus_status(evt_bus_status),
    .evt_err_ec96(evt_err_ec96), .evt_err_code(evt_err_code),
    .evt_tx_done(evt_tx_done), .evt_rx_done(evt_rx_done),
    .core_run_en(core_run_en), .wake_flag(wake_flag),
    .resume_ready(resume_ready), .err_irq(err_irq), .stat_irq(stat_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; step(1);
      bit_tick = 1'b0; step(1);
    end
  endtask

  task automatic to_run();
    rx_line = 1'b1; step(4);
    ticks(11);
    chk("R7 resume after warm-up", 32'(resume_ready), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; frame_active = 1'b0; arb_lost = 1'b0;
    err_event = 1'b0; core_irq = 1'b0; rx_line = 1'b1; bit_tick = 1'b0; global_ie = 1'b0;
    evt_bus_status = 1'b0; evt_err_ec96 = 1'b0; evt_err_code = 1'b0;
    evt_tx_done = 1'b0; evt_rx_done = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 rd_data", 32'(rd_data), 32'h0C);
    chk("R1 wake_flag", 32'(wake_flag), 32'd0);
    chk("R1 core_run_en", 32'(core_run_en), 32'd1);
    chk("R1 resume_ready", 32'(resume_ready), 32'd0);
    // R7 warm-up after reset
    step(3);
    ticks(10);
    chk("R7 not ready after 10", 32'(resume_ready), 32'd0);
    ticks(1);
    chk("R7 ready after 11", 32'(resume_ready), 32'd1);

    // R2 deferral by frame, R9 masked then shown, R10 gate
    frame_active = 1'b1;
    wr(8'h01);
    step(3);
    chk("R2 deferred by frame", 32'(wake_flag), 32'd0);
    chk("R9 pending sleep reads 0", 32'(rd_data[1:0]), 32'd0);
    chk("R10 run_en while pending", 32'(core_run_en), 32'd1);
    frame_active = 1'b0;
    step(1);
    chk("R2 entered after frame", 32'(wake_flag), 32'd1);
    chk("R10 run_en low", 32'(core_run_en), 32'd0);
    chk("R9 sleep shown", 32'(rd_data[1:0]), 32'd1);
    // R5 exit by clearing sleep; R7 dominant restart
    wr(8'h00);
    step(1);
    chk("R5 exit by clear", 32'(wake_flag), 32'd0);
    chk("R7 not ready on exit", 32'(resume_ready), 32'd0);
    ticks(5);
    rx_line = 1'b0; step(4);
    ticks(1);
    rx_line = 1'b1; step(4);
    ticks(10);
    chk("R7 dominant restarted count", 32'(resume_ready), 32'd0);
    ticks(1);
    chk("R7 ready after restart", 32'(resume_ready), 32'd1);

    // R2 arbitration lost; R6 power-down ignores bus
    arb_lost = 1'b1;
    wr(8'h02);
    step(3);
    chk("R2 deferred by arb_lost", 32'(wake_flag), 32'd0);
    chk("R9 pending pdown reads 0", 32'(rd_data[1:0]), 32'd0);
    arb_lost = 1'b0;
    step(1);
    chk("R2 pdown entered", 32'(wake_flag), 32'd1);
    chk("R9 pdown shown", 32'(rd_data[1:0]), 32'd2);
    rx_line = 1'b0; step(8);
    chk("R6 bus ignored", 32'(wake_flag), 32'd1);
    rx_line = 1'b1; step(4);
    chk("R6 still down", 32'(wake_flag), 32'd1);
    wr(8'h00);
    step(1);
    chk("R6 exit by clear", 32'(wake_flag), 32'd0);
    to_run();

    // R3 error forces entry during a frame
    frame_active = 1'b1;
    wr(8'h01);
    step(2);
    chk("R3 still deferred", 32'(wake_flag), 32'd0);
    err_event = 1'b1; step(1); err_event = 1'b0;
    chk("R3 entered on error", 32'(wake_flag), 32'd1);
    frame_active = 1'b0;
    // R9 both shown; R6 pdown with sleep blocks bus wake
    wr(8'h03);
    step(1);
    chk("R9 both shown", 32'(rd_data[1:0]), 32'd3);
    rx_line = 1'b0; step(6);
    chk("R6 pdown+sleep holds on bus", 32'(wake_flag), 32'd1);
    rx_line = 1'b1; step(4);
    wr(8'h01);
    step(2);
    chk("R9 sleep only shown", 32'(rd_data[1:0]), 32'd1);
    // R4 bus activity wake
    rx_line = 1'b0; step(5);
    chk("R4 bus wake", 32'(wake_flag), 32'd0);
    chk("R4 sleep bit cleared", 32'(rd_data[0]), 32'd0);
    to_run();

    // R5 controller-reset and software-interrupt exits
    wr(8'h01); step(1);
    chk("R5 entered before crst", 32'(wake_flag), 32'd1);
    wr(8'h04); step(1);
    chk("R5 exit by crst", 32'(wake_flag), 32'd0);
    to_run();
    wr(8'h01); step(1);
    chk("R5 entered before swint", 32'(wake_flag), 32'd1);
    wr(8'h08); step(1);
    chk("R5 exit by swint", 32'(wake_flag), 32'd0);
    to_run();
    wr(8'h05); step(3);
    chk("R5 sleep with crst not entered", 32'(wake_flag), 32'd0);

    // R8 abort in the same cycle the frame ends
    frame_active = 1'b1;
    wr(8'h01);
    step(1);
    frame_active = 1'b0; core_irq = 1'b1;
    step(1);
    core_irq = 1'b0;
    step(3);
    chk("R8 abort blocks entry", 32'(wake_flag), 32'd0);
    chk("R8 run_en stays", 32'(core_run_en), 32'd1);

    // R11/R12 sweep of enables and events
    for (int ie = 0; ie < 4; ie++) begin
      wr(8'((ie & 1) << 4 | ((ie >> 1) & 1) << 5));
      for (int v = 0; v < 64; v++) begin
        global_ie      = v[0];
        evt_bus_status = v[1];
        evt_err_ec96   = v[2];
        evt_err_code   = v[3];
        evt_tx_done    = v[4];
        evt_rx_done    = v[5];
        #1;
        chk("R11 err_irq", 32'(err_irq),
            32'(v[0] & ((ie >> 1) & 1) & (v[1] | v[2])));
        chk("R12 stat_irq", 32'(stat_irq),
            32'(v[0] & (ie & 1) & (v[3] | v[4] | v[5])));
      end
    end
    global_ie = 1'b1; evt_bus_status = 1'b0; evt_err_ec96 = 1'b0;
    evt_err_code = 1'b0; evt_tx_done = 1'b0; evt_rx_done = 1'b0;
    step(1);
    wr(8'h11); step(1);
    chk("R12 wake status raises irq", 32'(stat_irq), 32'd1);
    wr(8'h10); step(1);
    chk("R12 irq drops on exit", 32'(stat_irq), 32'd0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule